// File: doc/BRIEF.md
# Bidirectional Scaling Barrel Shifter

This block scales a fixed-point word up or down by any number of bit positions from zero to one less than the word width. A scale-up (left shift) brings zeros in at the least significant end. A scale-down (right shift) is arithmetic: it repeats the sign bit into the vacated high positions, so signed values keep their sign. A single control line picks the direction, and a binary shift amount of log2 of the width picks the distance.

The shift network is a chain of multiplexer stages, one for each bit of the shift amount. Stage k moves the word by 2^k places when its amount bit is set and passes the word through unchanged otherwise. Any distance therefore costs the same number of stages. The result is captured in one output register, so it appears one clock after the operands are presented.

Top module: `scl_barrel_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dout` becomes all zeros at that edge.
- R2: The result for `din`, `amt` and `dir_right` sampled at a rising edge appears on `dout` right after that edge and holds until the next edge.
- R3: When `amt` is 0, `dout` equals `din` for either value of `dir_right`.
- R4: When `dir_right` is 0 the block shifts left: `dout` equals `din` moved up by `amt` places, and the `amt` lowest bits are 0.
- R5: When `dir_right` is 1 the block shifts right arithmetically: `dout` equals `din` moved down by `amt` places, and the `amt` highest bits are copies of `din[W-1]`.
- R6: Every amount from 0 to W-1 is handled. At amount W-1, a left shift leaves only `din[0]` in the top bit, and a right shift leaves every bit equal to the sign.
- R7: Amounts that are powers of two, and their combinations, each give the displacement equal to the sum of the set amount-bit weights (stage k moves by 2^k).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | W | Data word to scale |
| amt | input | log2(W) | Shift distance |
| dir_right | input | 1 | 0 = left (zero fill), 1 = arithmetic right (sign fill) |
| dout | output | W | Registered shifted word |

## Verification
The bench builds the block at its default width of 16 with a 4-bit amount. With only 16 distances and two directions, every stage combination can be reached in both directions. A fixed table of vectors covers the edge distances 0 and 15 with sign bits set and clear. A random sweep then compares each result against the language's left-shift and arithmetic right-shift operators.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic {
    SCL_LEFT  = 1'b0,
    SCL_RIGHT = 1'b1
  } scl_dir_e;
endpackage

// File: rtl/scl_shift_stage.sv
module scl_shift_stage #(
  parameter int W = 16,
  parameter int K = 0
) (
  input  logic [W-1:0]        d_in,
  input  logic                en,
  input  scl_pkg::scl_dir_e   dir,
  output logic [W-1:0]        d_out
);
  localparam int D = 1 << K;

  logic [W-1:0] left_v;
  logic [W-1:0] right_v;

  assign left_v  = {d_in[W-1-D:0], {D{1'b0}}};
  assign right_v = {{D{d_in[W-1]}}, d_in[W-1:D]};

  always_comb begin
    if (!en)
      d_out = d_in;
    else if (dir == scl_pkg::SCL_RIGHT)
      d_out = right_v;
    else
      d_out = left_v;
  end
endmodule

// File: rtl/scl_shift_net.sv
module scl_shift_net #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]       d_in,
  input  logic [SW-1:0]      amt,
  input  scl_pkg::scl_dir_e  dir,
  output logic [W-1:0]       d_out
);
  logic [W-1:0] lvl [0:SW];

  assign lvl[0] = d_in;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    scl_shift_stage #(
      .W (W),
      .K (k)
    ) stage_i (
      .d_in  (lvl[k]),
      .en    (amt[k]),
      .dir   (dir),
      .d_out (lvl[k+1])
    );
  end

  assign d_out = lvl[SW];

  always_comb begin
    AST_SIGN_KEPT: assert (dir != scl_pkg::SCL_RIGHT || lvl[SW][W-1] == lvl[0][W-1]); // R5
    AST_ZERO_AMT_PASS: assert (amt != '0 || lvl[SW] == lvl[0]); // R3
  end
endmodule

// File: rtl/scl_barrel_top.sv
module scl_barrel_top #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          dir_right,
  output logic [W-1:0]  dout
);
  scl_pkg::scl_dir_e dir_sel;
  logic [W-1:0]      shifted;

  assign dir_sel = dir_right ? scl_pkg::SCL_RIGHT : scl_pkg::SCL_LEFT;

  scl_shift_net #(
    .W  (W),
    .SW (SW)
  ) net_i (
    .d_in  (din),
    .amt   (amt),
    .dir   (dir_sel),
    .d_out (shifted)
  );

  always_ff @(posedge clk) begin
    if (rst)
      dout <= '0;
    else
      dout <= shifted;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> dout == '0); // R1
  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (amt == '0) |=> dout == $past(din)); // R3
  AST_LEFT_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!dir_right && amt != '0) |=> dout[0] == 1'b0); // R4
  AST_LEFT_NO_GAIN: assert property (@(posedge clk) disable iff (rst)
    (!dir_right) |=> $countones(dout) <= $countones($past(din))); // R4
  AST_RIGHT_SIGN: assert property (@(posedge clk) disable iff (rst)
    (dir_right) |=> dout[W-1] == $past(din[W-1])); // R5
endmodule

// File: tb/scl_barrel_top_tb_top.sv
module scl_barrel_top_tb_top;
  localparam int W  = 16;
  localparam int SW = 4;
  localparam int NV = 12;
  localparam int VW = W + SW + 1 + W;

  // {din, amt, dir_right, expected}
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {16'h1234, 4'd4,  1'b0, 16'h2340},  // R4
    {16'h8001, 4'd1,  1'b1, 16'hC000},  // R5
    {16'h7FFF, 4'd15, 1'b1, 16'h0000},  // R6
    {16'h8000, 4'd15, 1'b1, 16'hFFFF},  // R6
    {16'h0001, 4'd15, 1'b0, 16'h8000},  // R6
    {16'hABCD, 4'd0,  1'b0, 16'hABCD},  // R3
    {16'hABCD, 4'd0,  1'b1, 16'hABCD},  // R3
    {16'hF0F0, 4'd8,  1'b1, 16'hFFF0},  // R7
    {16'h00FF, 4'd3,  1'b0, 16'h07F8},  // R7
    {16'h4000, 4'd2,  1'b1, 16'h1000},  // R7
    {16'hFFFF, 4'd15, 1'b0, 16'h8000},  // R6
    {16'h0F00, 4'd4,  1'b1, 16'h00F0}   // R5
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  din;
  logic [SW-1:0] amt;
  logic          dir_right;
  logic [W-1:0]  dout;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  scl_barrel_top #(.W(W), .SW(SW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .amt       (amt),
    .dir_right (dir_right),
    .dout      (dout)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // R2: inputs driven at a falling edge are loaded at the next rising edge
  task automatic apply(input logic [W-1:0] d, input logic [SW-1:0] a, input logic r,
                       input logic [W-1:0] exp, input string req);
    @(negedge clk);
    din = d; amt = a; dir_right = r;
    @(negedge clk);
    check(req, dout, exp);
  endtask

  initial begin
    rst = 1'b1; din = '0; amt = '0; dir_right = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", dout, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(v[VW-1 -: W], v[W+SW : W+1], v[W], v[W-1:0], "R4/R5/R6 table");
    end

    // R2: result holds while inputs are unchanged across another edge
    apply(16'h0123, 4'd1, 1'b0, 16'h0246, "R2");
    @(negedge clk);
    check("R2 hold", dout, 16'h0246);

    // R7: each single stage alone, both directions
    for (int k = 0; k < SW; k++) begin
      apply(16'h9001, 4'(1 << k), 1'b0, 16'h9001 << (1 << k), "R7 left");
      apply(16'h9001, 4'(1 << k), 1'b1, 16'($signed(16'h9001) >>> (1 << k)), "R7 right");
    end

    // R4/R5: random sweep against language operators
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0]  d;
      logic [SW-1:0] a;
      logic          r;
      logic [W-1:0]  e;
      d = W'($urandom);
      a = SW'($urandom);
      r = 1'($urandom);
      e = r ? W'($signed(d) >>> a) : W'(d << a);
      apply(d, a, r, e, r ? "R5 random" : "R4 random");
    end

    // R1: reset clears a nonzero result
    apply(16'h7777, 4'd0, 1'b0, 16'h7777, "R3");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 clear", dout, '0);
    rst = 1'b0;

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule